// File: doc/BRIEF.md
# Asynchronous DRAM Cycle Sequencer

This block sits between a simple host and an asynchronous fast-page-mode DRAM with a multiplexed address bus. The host presents one read or write at a time through a valid/ready handshake, with a 17-bit address and 8-bit data. The sequencer splits the address into a 9-bit row and an 8-bit column and places both on the shared address pins in turn. It drives the active-low row strobe, column strobe, write enable and output enable through a fixed order of phases. Read data comes back with a one-cycle valid pulse.

All analog timing limits are given as clock-cycle counts through parameters. These cover the minimum strobe widths, the row precharge, the row-to-column delay, the refresh setup, and the four access limits that bound when read data may be sampled. From the access limits the block derives the earliest safe sampling cycle.

A free-running interval timer marks a refresh as due. A due refresh runs as a column-strobe-first cycle at the next idle boundary, ahead of any waiting host request. The DQ pad is split into an output bus, an output-enable and an input bus, so the tri-state buffer sits outside the block.

Top module: `async_dram_ctrl`

## Requirements
- R1: During and right after reset all four strobes are high, the DQ output-enable is low, read-valid is low and the request-ready output is high.
- R2: Host address bits [16:8] form the row and bits [7:0] form the column, zero-extended on the 9-bit address bus. The row is on the bus and unchanged in the cycle where the row strobe falls. The column is on the bus and unchanged in the cycle where the column strobe falls.
- R3: A read keeps write enable high for its whole row-strobe-low period and lowers output enable only in read cycles. It returns the DQ input value as one single-cycle read-valid pulse per read.
- R4: A write lowers write enable before the column strobe falls. When the column strobe falls, the write data is on the DQ output with the output-enable high, and output enable stays high for the whole cycle.
- R5: Every row-strobe-low period lasts at least T_RAS clock cycles.
- R6: Every row-strobe-high period between two row-strobe-low periods lasts at least T_RP clock cycles.
- R7: A refresh lowers the column strobe at least T_CSR cycles before the row strobe falls. During the refresh, write enable and output enable stay high, the DQ output-enable stays low and no read-valid pulse occurs.
- R8: One refresh becomes due every REF_INTERVAL cycles (1560 by default, which keeps 512 refreshes within 8 ms at a 100 MHz clock). A due refresh starts before any waiting host request and never cuts short a host cycle in progress.
- R9: Request-ready is high only while the sequencer is idle with no refresh due. Each accepted request produces exactly one row/column access.
- R10: Read data is sampled in the first cycle in which all four access limits are met. These are row strobe low for T_RAC cycles, column address on the bus for T_CAA cycles, column strobe low for T_CAC cycles and output enable low for T_OAC cycles. Read-valid rises in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Sequencer can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Host byte address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle read data valid pulse |
| rdData | output | 8 | Read data |
| dramAddr | output | 9 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | 8 | Data toward the DRAM |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 8 | Data from the DRAM |

## Verification
The refresh timer and a host request can both be pending in the same idle cycle. The bench provokes this with a short refresh interval and an unbroken stream of requests, so reqValid is often already high when a refresh becomes due. The result is judged in three ways. Refreshes must keep their rate under load. Every refresh row-strobe fall seen while a request waits counts as a collision that was settled in the refresh's favour. Each waiting request must still get exactly one access that returns the correct data.

// File: rtl/adc_pkg.sv
package adc_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_RAS, S_COL, S_CAS, S_PRE, S_REFC, S_REFR
  } phase_e;

  // Strobes from control to datapath; each becomes a pin value one cycle later.
  typedef struct packed {
    logic load;     // capture host address/data
    logic useCol;   // address bus shows column (else row)
    logic rasLo;
    logic casLo;
    logic weLo;
    logic oeLo;
    logic driveDq;
    logic capture;  // sample DQ input this cycle
  } strobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_control.sv
module adc_control
  import adc_pkg::*;
#(
  parameter int T_RCD        = 2,
  parameter int T_RP         = 5,
  parameter int T_RAS        = 6,
  parameter int T_CSR        = 1,
  parameter int END_WR       = 1,
  parameter int END_RD       = 4,
  parameter int CAP_IDX      = 4,
  parameter int REF_INTERVAL = 1560
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  output logic    reqReady,
  output strobe_t stb
);

  localparam int CNT_MAX = maxOf(maxOf(T_RCD, T_RP), maxOf(maxOf(T_CSR, T_RAS), END_RD + 1));
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REF_W   = $clog2(REF_INTERVAL);

  phase_e           state, nxt;
  logic [CNT_W-1:0] phaseCnt;
  logic [REF_W-1:0] refTimer;
  logic             refPend;
  logic             refTick;
  logic             isWrite;
  logic             serveRef;

  assign refTick  = (refTimer == REF_W'(REF_INTERVAL - 1));
  assign serveRef = (state == S_IDLE) && refPend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer <= '0;
      refPend  <= 1'b0;
    end else begin
      refTimer <= refTick ? '0 : refTimer + 1'b1;
      refPend  <= refTick | (refPend & ~serveRef);
    end
  end

  always_comb begin
    nxt      = state;
    stb      = '0;
    reqReady = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = !refPend;
        if (refPend) begin
          nxt = S_REFC;
        end else if (reqValid) begin
          nxt      = S_ROW;
          stb.load = 1'b1;
        end
      end
      S_ROW: nxt = S_RAS;
      S_RAS: begin
        stb.rasLo = 1'b1;
        stb.weLo  = isWrite;
        if (phaseCnt == CNT_W'(T_RCD - 1)) nxt = S_COL;
      end
      S_COL: begin
        stb.rasLo   = 1'b1;
        stb.useCol  = 1'b1;
        stb.weLo    = isWrite;
        stb.driveDq = isWrite;
        stb.oeLo    = !isWrite;
        nxt         = S_CAS;
      end
      S_CAS: begin
        stb.rasLo   = 1'b1;
        stb.casLo   = 1'b1;
        stb.useCol  = 1'b1;
        stb.weLo    = isWrite;
        stb.driveDq = isWrite;
        stb.oeLo    = !isWrite;
        stb.capture = !isWrite && (phaseCnt == CNT_W'(CAP_IDX));
        if (isWrite ? (phaseCnt == CNT_W'(END_WR)) : (phaseCnt == CNT_W'(END_RD)))
          nxt = S_PRE;
      end
      S_PRE: begin
        if (phaseCnt == CNT_W'(T_RP - 1)) nxt = S_IDLE;
      end
      S_REFC: begin
        stb.casLo = 1'b1;
        if (phaseCnt == CNT_W'(T_CSR - 1)) nxt = S_REFR;
      end
      S_REFR: begin
        stb.casLo = 1'b1;
        stb.rasLo = 1'b1;
        if (phaseCnt == CNT_W'(T_RAS - 1)) nxt = S_PRE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
    end else begin
      state    <= nxt;
      phaseCnt <= (nxt != state) ? '0 : phaseCnt + 1'b1;
      if (stb.load) isWrite <= reqWrite;
    end
  end

  // R9: an accepted request always opens a row phase next cycle
  a_r9_accept_opens_row: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (state == S_ROW));

  // R8: a due refresh at an idle boundary wins over any host request
  a_r8_refresh_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && refPend) |=> (state == S_REFC));

endmodule

// File: rtl/adc_datapath.sv
module adc_datapath
  import adc_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 8,
  parameter int DATA_W = 8,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        dramDqIn,
  output logic [maxOf(ROW_W,COL_W)-1:0] dramAddr,
  output logic                     dramRasN,
  output logic                     dramCasN,
  output logic                     dramWeN,
  output logic                     dramOeN,
  output logic [DATA_W-1:0]        dramDqOut,
  output logic                     dramDqOe,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int BUS_W  = maxOf(ROW_W, COL_W);

  logic [ADDR_W-1:0] latAddr;
  logic [DATA_W-1:0] latData;
  logic [ROW_W-1:0]  rowPart;
  logic [COL_W-1:0]  colPart;

  assign rowPart = latAddr[ADDR_W-1:COL_W];
  assign colPart = latAddr[COL_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr   <= '0;
      latData   <= '0;
      dramAddr  <= '0;
      dramRasN  <= 1'b1;
      dramCasN  <= 1'b1;
      dramWeN   <= 1'b1;
      dramOeN   <= 1'b1;
      dramDqOut <= '0;
      dramDqOe  <= 1'b0;
      rdValid   <= 1'b0;
      rdData    <= '0;
    end else begin
      if (stb.load) begin
        latAddr <= reqAddr;
        latData <= reqWdata;
      end
      dramAddr  <= stb.useCol ? BUS_W'(colPart) : BUS_W'(rowPart);
      dramRasN  <= !stb.rasLo;
      dramCasN  <= !stb.casLo;
      dramWeN   <= !stb.weLo;
      dramOeN   <= !stb.oeLo;
      dramDqOut <= latData;
      dramDqOe  <= stb.driveDq;
      rdValid   <= stb.capture;
      if (stb.capture) rdData <= dramDqIn;
    end
  end

  // Pin run-length counters used only by the assertions below.
  localparam int RUN_MAX = maxOf(T_RAS, T_RP) + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  logic [RUN_W-1:0] rasLowRun, rasHighRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasLowRun  <= '0;
      rasHighRun <= RUN_W'(RUN_MAX);
    end else begin
      rasLowRun  <= dramRasN ? '0
                  : (rasLowRun == RUN_W'(RUN_MAX) ? rasLowRun : rasLowRun + 1'b1);
      rasHighRun <= !dramRasN ? '0
                  : (rasHighRun == RUN_W'(RUN_MAX) ? rasHighRun : rasHighRun + 1'b1);
    end
  end

  a_r2_row_settled: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && dramCasN) |-> $stable(dramAddr));

  a_r2_col_settled: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramRasN) |-> $stable(dramAddr));

  a_r4_we_leads_cas: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasN) && !dramRasN && !dramWeN) |-> ($past(!dramWeN) && dramDqOe));

  a_r7_refresh_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && !dramCasN) |-> (dramWeN && dramOeN && !dramDqOe));

  a_r3_oe_reads_only: assert property (@(posedge clk) disable iff (!rstN)
    !dramOeN |-> (dramWeN && !dramDqOe));

  a_r3_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  a_r5_ras_active_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dramRasN) |-> (int'(rasLowRun) >= T_RAS));

  a_r6_precharge_min: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (int'(rasHighRun) >= T_RP));

endmodule

// File: rtl/async_dram_ctrl.sv
module async_dram_ctrl
  import adc_pkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 8,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 5,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_CSR        = 1,
  parameter int T_RAC        = 6,
  parameter int T_CAA        = 3,
  parameter int T_CAC        = 2,
  parameter int T_OAC        = 2,
  parameter int REF_INTERVAL = 1560
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic                          reqWrite,
  input  logic [ROW_W+COL_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]             reqWdata,
  output logic                          rdValid,
  output logic [DATA_W-1:0]             rdData,
  output logic [maxOf(ROW_W,COL_W)-1:0] dramAddr,
  output logic                          dramRasN,
  output logic                          dramCasN,
  output logic                          dramWeN,
  output logic                          dramOeN,
  output logic [DATA_W-1:0]             dramDqOut,
  output logic                          dramDqOe,
  input  logic [DATA_W-1:0]             dramDqIn
);

  // Sampling index inside the column phase (0 = first cycle the column
  // strobe is commanded low): the latest of the four access limits.
  localparam int CAP_IDX = maxOf(maxOf(T_CAC, T_CAA - 1),
                                 maxOf(T_OAC - 1, T_RAC - T_RCD - 1));
  // Last column-phase index: column strobe width and row active minimum.
  localparam int END_WR  = maxOf(maxOf(T_CAS - 1, T_RAS - T_RCD - 2), 0);
  localparam int END_RD  = maxOf(END_WR, CAP_IDX);

  strobe_t stb;

  adc_control #(
    .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_CSR(T_CSR),
    .END_WR(END_WR), .END_RD(END_RD), .CAP_IDX(CAP_IDX),
    .REF_INTERVAL(REF_INTERVAL)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  adc_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramDqIn(dramDqIn), .dramAddr(dramAddr), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramOeN(dramOeN),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: tb/async_dram_ctrl_test.sv
module async_dram_ctrl_test;

  localparam int T_RAS = 5, T_RP = 3, T_RCD = 2, T_CAS = 2, T_CSR = 2;
  localparam int T_RAC = 7, T_CAA = 3, T_CAC = 2, T_OAC = 2, REF_INT = 80;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rdValid;
  logic [7:0]  rdData, dramDqOut;
  logic [7:0]  dramDqIn = '0;
  logic [8:0]  dramAddr;
  logic        dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;

  async_dram_ctrl #(
    .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CSR(T_CSR),
    .T_RAC(T_RAC), .T_CAA(T_CAA), .T_CAC(T_CAC), .T_OAC(T_OAC),
    .REF_INTERVAL(REF_INT)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramDqOut(dramDqOut), .dramDqOe(dramDqOe),
    .dramDqIn(dramDqIn)
  );

  int compared = 0, mismatched = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bench-side DRAM model and host shadow
  logic [7:0] mem    [int];
  logic [7:0] shadow [int];

  logic [16:0] curAddr = '0;
  logic [7:0]  curData = '0, expData = '0;
  bit   curWrite = 0, pendingRead = 0, inRefresh = 0;
  bit   weSeen = 0, oeSeen = 0, prevRdValid = 0;
  logic prevRas = 1, prevCas = 1, prevWe = 1;
  int   rasLowRun = 0, rasHighRun = 1000, casLowRun = 0, oeLowRun = 0, colRun = 0;
  int   cyc = 0, firstValid = -1, refCount = 0, collisions = 0;
  int   accessCount = 0, issueCount = 0;
  logic [8:0] rowLat = '0, colLat = '0;

  function automatic logic [8:0] rowOf(input logic [16:0] a); return a[16:8]; endfunction
  function automatic logic [8:0] colOf(input logic [16:0] a); return {1'b0, a[7:0]}; endfunction
  function automatic logic [7:0] memAt(input int k); return mem.exists(k) ? mem[k] : 8'h00; endfunction

  always @(negedge clk) begin
    if (rstN) begin
      bit validNow;
      int key;
      cyc++;
      // row strobe fall
      if (!dramRasN && prevRas) begin
        check(rasHighRun >= T_RP, "R6 precharge width", rasHighRun, T_RP);
        if (!dramCasN) begin
          inRefresh = 1;
          refCount++;
          if (reqValid) collisions++;
          check(casLowRun >= T_CSR, "R7 cas lead before ras", casLowRun, T_CSR);
          check(dramWeN && dramOeN && !dramDqOe, "R7 refresh pins quiet",
                {dramWeN, dramOeN, dramDqOe}, 3'b110);
        end else begin
          inRefresh = 0;
          accessCount++;
          rowLat = dramAddr;
          check(dramAddr == rowOf(curAddr), "R2 row at ras fall", dramAddr, rowOf(curAddr));
        end
        weSeen = 0;
        oeSeen = 0;
      end
      // column strobe fall inside an access
      if (!dramCasN && prevCas && !dramRasN) begin
        colLat = dramAddr;
        check(dramAddr == colOf(curAddr), "R2 column at cas fall", dramAddr, colOf(curAddr));
        if (curWrite) begin
          check(prevWe == 1'b0, "R4 we low before cas", prevWe, 0);
          check(dramDqOe && dramDqOut == curData, "R4 write data at cas fall",
                {dramDqOe, dramDqOut}, {1'b1, curData});
          mem[int'(rowLat) * 256 + int'(colLat)] = dramDqOut;
        end else begin
          check(dramWeN == 1'b1, "R3 we high at read cas", dramWeN, 1);
        end
      end
      // row strobe rise
      if (dramRasN && !prevRas) begin
        check(rasLowRun >= T_RAS, "R5 ras active width", rasLowRun, T_RAS);
        if (inRefresh) begin
          check(!weSeen && !oeSeen, "R7 no we/oe in refresh", {weSeen, oeSeen}, 0);
        end else begin
          check(oeSeen == !curWrite, "R3 oe only in reads", oeSeen, !curWrite);
          check(weSeen == curWrite, "R3 we high through read", weSeen, curWrite);
        end
      end
      if (!dramRasN) begin
        if (!dramWeN) weSeen = 1;
        if (!dramOeN) oeSeen = 1;
        check(!reqReady, "R9 not ready while busy", reqReady, 0);
      end
      if (dramDqOe) check(!dramRasN && !inRefresh, "R7 dq driven only in access", dramRasN, 0);

      rasLowRun  = dramRasN ? 0 : rasLowRun + 1;
      rasHighRun = dramRasN ? rasHighRun + 1 : 0;
      casLowRun  = dramCasN ? 0 : casLowRun + 1;
      oeLowRun   = dramOeN ? 0 : oeLowRun + 1;
      colRun     = (!dramRasN && !inRefresh && dramAddr == colOf(curAddr)) ? colRun + 1 : 0;

      if (rdValid) begin
        check(pendingRead && !inRefresh, "R3 valid only for a read", pendingRead, 1);
        check(rdData == expData, "R3 read data", rdData, expData);
        check(firstValid >= 0 && cyc == firstValid + 1, "R10 capture cycle", cyc, firstValid + 1);
        pendingRead = 0;
      end
      if (prevRdValid) check(!rdValid, "R3 single-cycle valid", rdValid, 0);
      prevRdValid = rdValid;

      validNow = pendingRead && !inRefresh && !dramRasN && !dramCasN && dramWeN && !dramOeN
                 && rasLowRun >= T_RAC && casLowRun >= T_CAC
                 && colRun >= T_CAA && oeLowRun >= T_OAC;
      if (validNow && firstValid < 0) firstValid = cyc;
      key = int'(rowLat) * 256 + int'(dramAddr[7:0]);
      dramDqIn = validNow ? memAt(key) : ~memAt(key);

      prevRas = dramRasN;
      prevCas = dramCasN;
      prevWe  = dramWeN;
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = a;
    reqWdata = d;
    while (!reqReady) @(negedge clk);
    curAddr  = a;
    curWrite = wr;
    curData  = d;
    issueCount++;
    if (wr) shadow[int'(a)] = d;
    else begin
      expData     = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      pendingRead = 1;
      firstValid  = -1;
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check({dramRasN, dramCasN, dramWeN, dramOeN} == 4'hF, "R1 strobes high in reset",
          {dramRasN, dramCasN, dramWeN, dramOeN}, 4'hF);
    check(!dramDqOe && !rdValid, "R1 dq and valid low in reset", {dramDqOe, rdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady && dramRasN && dramCasN, "R1 ready after reset",
          {reqReady, dramRasN, dramCasN}, 3'b111);

    // walking-one addresses: row and column fields exercised bit by bit
    for (int i = 0; i < 17; i++) issue(1'b1, 17'(1) << i, 8'(i * 13 + 7));
    for (int i = 0; i < 17; i++) issue(1'b0, 17'(1) << i, 8'h00);

    // full column sweep in one row, written then read back
    for (int c = 0; c < 256; c++) issue(1'b1, {9'h1A5, 8'(c)}, 8'(c) ^ 8'h3C);
    for (int c = 0; c < 256; c++) issue(1'b0, {9'h1A5, 8'(c)}, 8'h00);

    // back-to-back reverse stream: refresh collides with waiting requests
    for (int c = 255; c >= 0; c--) issue(1'b0, {9'h1A5, 8'(c)}, 8'h00);

    repeat (40) @(negedge clk);
    check(!pendingRead, "R3 every read returned", pendingRead, 0);
    check(accessCount == issueCount, "R9 one access per request", accessCount, issueCount);
    check(collisions > 0, "R8 refresh won over waiting request", collisions, 1);
    check(refCount >= cyc / REF_INT - 1 && refCount <= cyc / REF_INT,
          "R8 refresh rate", refCount, cyc / REF_INT);
    finishRun();
  end

endmodule